// File: doc/BRIEF.md
# Timekeeper Hold, Busy and Seconds-Rounding Controller

This block sits between the sub-second time base of a calendar clock and its digit counters. It owns the sub-second prescaler, which counts enable ticks of the 32.768 kHz domain and produces one advance pulse for the seconds digit on each wrap. It also holds the two control nibbles that govern timekeeping. The first holds the freeze request and the rounding request and reports the update window. The second holds the format, stop and reset bits. A separate flag records that the oscillator has stopped.

Software freezes the digits by setting the freeze bit. If the update window was not open at that moment, second carries are held back so the digits can be read or rewritten safely. One held-back carry is replayed as soon as the freeze is released, and any extra carries during the same freeze are lost. A rounding request clears the seconds, carries into the minutes when they were 30 or more, and then stays visible as a self-clearing bit for a fixed number of ticks. While that bit is visible, digit writes and reset requests are refused. Deasserting chip select drops the freeze and reset bits at once.

Top module: `hold_adj_ctl`

## Requirements
- R1: While neither stop nor reset is set, `presc_o` increments on each cycle with `tick_i` high and wraps from all ones to zero; `sec_adv_o` pulses in the wrap cycle unless R3 or R6 withholds it.
- R2: With stop (bit 1 of the F nibble) set, `presc_o` stays constant; with reset (bit 0 of the F nibble) set, `presc_o` becomes zero on the next edge and stays there.
- R3: With the freeze bit (bit 0 of the D nibble) set and the sampled window flag 0, no advance pulses occur. When the freeze is released, exactly one pulse is issued in the release cycle if at least one carry was withheld or a carry falls in that cycle; further withheld carries are lost.
- R4: The update window covers the last BUSY_TICKS prescaler values before the wrap while running. It is sampled when the freeze bit goes from 0 to 1. `busy_o` shows the sample while frozen and reads 1 while not frozen. A freeze taken with the sample at 1 does not withhold carries.
- R5: `dig_wr_en_o` is high only for a request made with chip select high, the freeze bit set, the sampled window flag 0 and no rounding in progress.
- R6: A selected write of the D nibble with bit 3 set, made while no rounding is active, pulses `sec_clr_o` in that cycle. It pulses `min_carry_o` too when `sec_tens_i` is 3 or more, and it suppresses any advance pulse in that cycle.
- R7: `adj_o` rises after a rounding start and falls on the ADJ_TICKS-th tick after it rose. A further rounding write while `adj_o` is 1 gives no pulse and no restart.
- R8: While `adj_o` is 1, a write setting the reset bit leaves `rest_o` unchanged; writing the reset bit to 0 still takes effect.
- R9: With `chip_sel_i` low, `hold_o` and `rest_o` are 0 after the next edge, and writes of both nibbles are ignored.
- R10: `osc_flag_o` is 1 after reset, becomes 1 after any cycle with `osc_ok_i` low, and is cleared by `flag_clr_i` only in a cycle with `osc_ok_i` high.
- R11: `ctl_d_rd_o` is {adjust, 0, busy, freeze} from bit 3 down to bit 0; `ctl_f_rd_o` is {0, 24-hour format, stop, reset}.
- R12: After reset, freeze, stop, reset, format, rounding and prescaler are zero, `busy_o` reads 1 and `osc_flag_o` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| chip_sel_i | input | 1 | Chip-select level, high when selected |
| ctl_d_wr_i | input | 1 | Write strobe for the D nibble |
| ctl_f_wr_i | input | 1 | Write strobe for the F nibble |
| wdata_i | input | 4 | Write data for either nibble |
| dig_wr_req_i | input | 1 | Request to write a time digit |
| sec_tens_i | input | 3 | Current tens-of-seconds digit |
| osc_ok_i | input | 1 | Oscillator running indication |
| flag_clr_i | input | 1 | Software write of 0 to the oscillator-stopped flag |
| presc_o | output | PRESC_W | Sub-second prescaler value |
| sec_adv_o | output | 1 | Advance pulse for the seconds digit |
| sec_clr_o | output | 1 | Clear pulse for the seconds digits (rounding) |
| min_carry_o | output | 1 | Carry pulse into the minutes (rounding) |
| dig_wr_en_o | output | 1 | Digit write accepted |
| busy_o | output | 1 | Update-window status as seen by software |
| hold_o | output | 1 | Freeze bit |
| stop_o | output | 1 | Stop bit |
| rest_o | output | 1 | Prescaler reset bit |
| fmt24_o | output | 1 | 24-hour format bit |
| adj_o | output | 1 | Rounding in progress |
| osc_flag_o | output | 1 | Oscillator-stopped flag |
| ctl_d_rd_o | output | 4 | Read view of the D nibble |
| ctl_f_rd_o | output | 4 | Read view of the F nibble |

## Verification
Two collisions are provoked on purpose with ticks on every cycle: the freeze release is written exactly in the cycle where the prescaler wraps, and a rounding request is written in a wrap cycle. The bench waits until the prescaler shows the value one below the wrap and issues the write on the following cycle. It then compares the number of advance pulses against the requirement: one pulse for a release in a wrap cycle, with or without a carry already held back, and none for a rounding in a wrap cycle. The behavioural model is compared on every clock as well, so any extra or missing pulse around these cycles is reported.

// File: rtl/hac_pkg.sv
package hac_pkg;

    // Bit positions inside the two control nibbles (decoded by the bus side).
    localparam int unsigned D_ADJ_BIT   = 3;
    localparam int unsigned D_BUSY_BIT  = 1;
    localparam int unsigned D_HOLD_BIT  = 0;
    localparam int unsigned F_FMT_BIT   = 2;
    localparam int unsigned F_STOP_BIT  = 1;
    localparam int unsigned F_REST_BIT  = 0;

    // Tens-of-seconds value from which rounding carries into the minutes.
    localparam int unsigned ROUND_UP_TENS = 3;

    typedef struct packed {
        logic hold;   // freeze request
        logic stop;   // stop timekeeping
        logic rest;   // clear and stop prescaler
        logic fmt24;  // 24-hour format
        logic pend;   // one withheld second carry
        logic bsmp;   // window flag sampled at freeze
        logic flag;   // oscillator-stopped flag
    } ctl_t;

endpackage

// File: rtl/hac_prescaler.sv
module hac_prescaler #(
    parameter int unsigned W          = 15,
    parameter int unsigned BUSY_TICKS = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         clear_i,
    output logic [W-1:0] cnt_o,
    output logic         carry_o,
    output logic         busy_win_o
);
    localparam logic [W-1:0] LAST       = {W{1'b1}};
    localparam logic [W-1:0] BUSY_START = LAST - W'(BUSY_TICKS - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && run_i) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o      = cnt_q;
    assign carry_o    = tick_i && run_i && (cnt_q == LAST);
    assign busy_win_o = run_i && (cnt_q >= BUSY_START);

endmodule

// File: rtl/hac_adj_timer.sv
module hac_adj_timer #(
    parameter int unsigned TICKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    output logic active_o
);
    localparam int unsigned     CW   = $clog2(TICKS + 1);
    localparam logic [CW-1:0]   LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } adj_t;

    adj_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

endmodule

// File: rtl/hold_adj_ctl.sv
module hold_adj_ctl
    import hac_pkg::*;
#(
    parameter int unsigned PRESC_W    = 15,
    parameter int unsigned BUSY_TICKS = 7,
    parameter int unsigned ADJ_TICKS  = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               chip_sel_i,
    input  logic               ctl_d_wr_i,
    input  logic               ctl_f_wr_i,
    input  logic [3:0]         wdata_i,
    input  logic               dig_wr_req_i,
    input  logic [2:0]         sec_tens_i,
    input  logic               osc_ok_i,
    input  logic               flag_clr_i,
    output logic [PRESC_W-1:0] presc_o,
    output logic               sec_adv_o,
    output logic               sec_clr_o,
    output logic               min_carry_o,
    output logic               dig_wr_en_o,
    output logic               busy_o,
    output logic               hold_o,
    output logic               stop_o,
    output logic               rest_o,
    output logic               fmt24_o,
    output logic               adj_o,
    output logic               osc_flag_o,
    output logic [3:0]         ctl_d_rd_o,
    output logic [3:0]         ctl_f_rd_o
);
    ctl_t st_d, st_q;

    logic run, carry, busy_win, adj_active;
    logic d_wr, f_wr, adj_start, held, rel;

    assign run = !st_q.stop && !st_q.rest;

    hac_prescaler #(
        .W          (PRESC_W),
        .BUSY_TICKS (BUSY_TICKS)
    ) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (run),
        .clear_i    (st_q.rest),
        .cnt_o      (presc_o),
        .carry_o    (carry),
        .busy_win_o (busy_win)
    );

    hac_adj_timer #(
        .TICKS (ADJ_TICKS)
    ) u_adj (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .start_i  (adj_start),
        .active_o (adj_active)
    );

    always_comb begin
        d_wr      = chip_sel_i && ctl_d_wr_i;
        f_wr      = chip_sel_i && ctl_f_wr_i;
        adj_start = d_wr && wdata_i[D_ADJ_BIT] && !adj_active;
        held      = st_q.hold && !st_q.bsmp;

        st_d = st_q;
        if (d_wr) begin
            st_d.hold = wdata_i[D_HOLD_BIT];
        end
        if (f_wr) begin
            st_d.fmt24 = wdata_i[F_FMT_BIT];
            st_d.stop  = wdata_i[F_STOP_BIT];
            if (!(wdata_i[F_REST_BIT] && adj_active)) begin
                st_d.rest = wdata_i[F_REST_BIT];
            end
        end
        if (!chip_sel_i) begin
            st_d.hold = 1'b0;
            st_d.rest = 1'b0;
        end

        // Window flag is captured on the 0 -> 1 edge of the freeze bit.
        if (!st_q.hold && st_d.hold) begin
            st_d.bsmp = busy_win;
        end

        rel = held && !st_d.hold;
        if (rel) begin
            st_d.pend = 1'b0;
        end else if (held && carry) begin
            st_d.pend = 1'b1;
        end

        if (!osc_ok_i) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end

        if (held) begin
            sec_adv_o = rel && (st_q.pend || carry) && !adj_start;
        end else begin
            sec_adv_o = carry && !adj_start;
        end
        sec_clr_o   = adj_start;
        min_carry_o = adj_start && (sec_tens_i >= 3'(ROUND_UP_TENS));
        dig_wr_en_o = dig_wr_req_i && chip_sel_i && held && !adj_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.hold ? st_q.bsmp : 1'b1;
    assign hold_o     = st_q.hold;
    assign stop_o     = st_q.stop;
    assign rest_o     = st_q.rest;
    assign fmt24_o    = st_q.fmt24;
    assign adj_o      = adj_active;
    assign osc_flag_o = st_q.flag;

    always_comb begin
        ctl_d_rd_o             = '0;
        ctl_d_rd_o[D_ADJ_BIT]  = adj_active;
        ctl_d_rd_o[D_BUSY_BIT] = busy_o;
        ctl_d_rd_o[D_HOLD_BIT] = st_q.hold;
        ctl_f_rd_o             = '0;
        ctl_f_rd_o[F_FMT_BIT]  = st_q.fmt24;
        ctl_f_rd_o[F_STOP_BIT] = st_q.stop;
        ctl_f_rd_o[F_REST_BIT] = st_q.rest;
    end

endmodule

// File: rtl/hac_checker.sv
module hac_checker #(
    parameter int unsigned PRESC_W   = 15,
    parameter int unsigned ADJ_TICKS = 4096
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic               chip_sel_i,
    input logic               osc_ok_i,
    input logic [PRESC_W-1:0] presc_o,
    input logic               sec_adv_o,
    input logic               sec_clr_o,
    input logic               dig_wr_en_o,
    input logic               busy_o,
    input logic               hold_o,
    input logic               stop_o,
    input logic               rest_o,
    input logic               adj_o,
    input logic               osc_flag_o
);
    // Ticks seen while the rounding bit is up.
    logic [31:0] acnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt <= '0;
        end else if (!adj_o) begin
            acnt <= '0;
        end else if (tick_i) begin
            acnt <= acnt + 32'd1;
        end
    end

    a_r3_adv_frozen_only_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        sec_adv_o && hold_o && !busy_o |=> !hold_o);

    a_r9_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel_i |=> !hold_o && !rest_o);

    a_r7_adj_duration: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adj_o) |-> ($past(acnt) == 32'(ADJ_TICKS - 1)) && $past(tick_i));

    a_r5_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dig_wr_en_o |-> chip_sel_i && hold_o && !busy_o && !adj_o);

    a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_ok_i |=> osc_flag_o);

    a_r2_rest_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        rest_o |=> presc_o == '0);

    a_r2_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o && !rest_o |=> $stable(presc_o));

    a_r6_clear_starts_adjust: assert property (@(posedge clk) disable iff (!rst_n)
        sec_clr_o |=> adj_o);

endmodule

bind hold_adj_ctl hac_checker #(
    .PRESC_W   (PRESC_W),
    .ADJ_TICKS (ADJ_TICKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .chip_sel_i  (chip_sel_i),
    .osc_ok_i    (osc_ok_i),
    .presc_o     (presc_o),
    .sec_adv_o   (sec_adv_o),
    .sec_clr_o   (sec_clr_o),
    .dig_wr_en_o (dig_wr_en_o),
    .busy_o      (busy_o),
    .hold_o      (hold_o),
    .stop_o      (stop_o),
    .rest_o      (rest_o),
    .adj_o       (adj_o),
    .osc_flag_o  (osc_flag_o)
);

// File: tb/tb_hold_adj_ctl.sv
module tb_hold_adj_ctl;
    localparam int PW   = 6;
    localparam int SEC  = 64;
    localparam int BUSY = 7;
    localparam int ADJ  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic chip_sel_i = 1'b1;
    logic ctl_d_wr_i = 1'b0;
    logic ctl_f_wr_i = 1'b0;
    logic [3:0] wdata_i = '0;
    logic dig_wr_req_i = 1'b0;
    logic [2:0] sec_tens_i = '0;
    logic osc_ok_i = 1'b1;
    logic flag_clr_i = 1'b0;

    logic [PW-1:0] presc_o;
    logic sec_adv_o, sec_clr_o, min_carry_o, dig_wr_en_o, busy_o, hold_o;
    logic stop_o, rest_o, fmt24_o, adj_o, osc_flag_o;
    logic [3:0] ctl_d_rd_o, ctl_f_rd_o;

    hold_adj_ctl #(.PRESC_W(PW), .BUSY_TICKS(BUSY), .ADJ_TICKS(ADJ)) dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit tick_all = 1'b0;
    int tcnt = 0;
    int adv_cnt = 0, clr_cnt = 0, min_cnt = 0;

    // model state
    bit m_hold, m_stop, m_rest, m_fmt, m_adj, m_pend, m_bsmp, m_flag;
    int m_acnt, m_presc;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        tcnt++;
        tick_i = tick_all ? 1'b1 : ((tcnt % 3) != 0);
    end

    always @(negedge clk) begin
        #4;
        if (!rst_n) begin
            m_hold = 0; m_stop = 0; m_rest = 0; m_fmt = 0; m_adj = 0;
            m_pend = 0; m_bsmp = 0; m_flag = 1; m_acnt = 0; m_presc = 0;
        end else begin
            bit run, carry, braw, heff, astart, hn, rl, adv, dw, fw;
            int busy_e;
            run    = !m_stop && !m_rest;
            carry  = tick_i && run && (m_presc == SEC - 1);
            braw   = run && (m_presc >= SEC - BUSY);
            heff   = m_hold && !m_bsmp;
            dw     = chip_sel_i && ctl_d_wr_i;
            fw     = chip_sel_i && ctl_f_wr_i;
            astart = dw && wdata_i[3] && !m_adj;
            hn     = !chip_sel_i ? 1'b0 : (dw ? wdata_i[0] : m_hold);
            rl     = heff && !hn;
            adv    = (heff ? (rl && (m_pend || carry)) : carry) && !astart;
            busy_e = m_hold ? int'(m_bsmp) : 1;

            if (sec_adv_o) adv_cnt++;
            if (sec_clr_o) clr_cnt++;
            if (min_carry_o) min_cnt++;

            chk("R1 prescaler", int'(presc_o), m_presc);
            chk("R1/R3 advance pulse", int'(sec_adv_o), int'(adv));
            chk("R6 seconds clear", int'(sec_clr_o), int'(astart));
            chk("R6 minute carry", int'(min_carry_o), int'(astart && sec_tens_i >= 3));
            chk("R5 digit write enable", int'(dig_wr_en_o),
                int'(dig_wr_req_i && chip_sel_i && heff && !m_adj));
            chk("R4 busy", int'(busy_o), busy_e);
            chk("R9 hold", int'(hold_o), int'(m_hold));
            chk("R2 stop", int'(stop_o), int'(m_stop));
            chk("R8 rest", int'(rest_o), int'(m_rest));
            chk("R7 adjust", int'(adj_o), int'(m_adj));
            chk("R10 osc flag", int'(osc_flag_o), int'(m_flag));
            chk("R11 D view", int'(ctl_d_rd_o),
                int'(m_adj) * 8 + busy_e * 2 + int'(m_hold));
            chk("R11 F view", int'(ctl_f_rd_o),
                int'(m_fmt) * 4 + int'(m_stop) * 2 + int'(m_rest));

            // next state
            if (m_rest) m_presc = 0;
            else if (tick_i && run) m_presc = (m_presc + 1) % SEC;
            if (rl) m_pend = 0;
            else if (heff && carry) m_pend = 1;
            if (!m_hold && hn) m_bsmp = braw;
            if (fw) begin
                m_fmt  = wdata_i[2];
                m_stop = wdata_i[1];
                if (!(wdata_i[0] && m_adj)) m_rest = wdata_i[0];
            end
            if (!chip_sel_i) m_rest = 0;
            if (astart) begin
                m_adj = 1; m_acnt = 0;
            end else if (m_adj && tick_i) begin
                if (m_acnt == ADJ - 1) begin m_adj = 0; m_acnt = 0; end
                else m_acnt++;
            end
            if (!osc_ok_i) m_flag = 1;
            else if (flag_clr_i) m_flag = 0;
            m_hold = hn;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_d(input logic [3:0] v);
        @(negedge clk);
        ctl_d_wr_i = 1'b1; wdata_i = v;
        @(negedge clk);
        ctl_d_wr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic wr_f(input logic [3:0] v);
        @(negedge clk);
        ctl_f_wr_i = 1'b1; wdata_i = v;
        @(negedge clk);
        ctl_f_wr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic wait_presc(input int v);
        do @(negedge clk); while (int'(presc_o) != v);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int a0, c0, n0, p;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        #4;
        // R12 reset state
        chk("R12 reset hold", int'(hold_o), 0);
        chk("R12 reset busy", int'(busy_o), 1);
        chk("R12 reset flag", int'(osc_flag_o), 1);
        chk("R12 reset adjust", int'(adj_o), 0);

        // R10 oscillator flag
        @(negedge clk) flag_clr_i = 1'b1;
        @(negedge clk) flag_clr_i = 1'b0;
        chk("R10 flag cleared", int'(osc_flag_o), 0);
        osc_ok_i = 1'b0; idle(2);
        flag_clr_i = 1'b1; idle(1);
        chk("R10 flag kept while stopped", int'(osc_flag_o), 1);
        osc_ok_i = 1'b1; idle(1);
        flag_clr_i = 1'b0;
        chk("R10 flag cleared after restart", int'(osc_flag_o), 0);

        // R1 free running across several wraps
        a0 = adv_cnt;
        idle(300);
        chk("R1 advances seen", int'(adv_cnt - a0 >= 2), 1);

        // R2 stop and reset
        wr_f(4'b0010);
        p = int'(presc_o);
        idle(20);
        chk("R2 stop holds prescaler", int'(presc_o), p);
        wr_f(4'b0001);
        idle(3);
        chk("R2 reset clears prescaler", int'(presc_o), 0);
        wr_f(4'b0000);

        // R11 F nibble view
        wr_f(4'b0110);
        chk("R11 F view fields", int'(ctl_f_rd_o), 6);
        wr_f(4'b0000);

        // R3 freeze across two carries, one replay
        wait_presc(10);
        a0 = adv_cnt;
        wr_d(4'b0001);
        dig_wr_req_i = 1'b1;
        idle(1);
        chk("R5 write accepted while frozen", int'(dig_wr_en_o), 1);
        wait_presc(20); wait_presc(20); wait_presc(20);
        dig_wr_req_i = 1'b0;
        wr_d(4'b0000);
        chk("R3 single replay after two carries", adv_cnt - a0, 1);

        // R3 collision: release in wrap cycle, nothing withheld
        tick_all = 1'b1;
        wait_presc(30);
        a0 = adv_cnt;
        wr_d(4'b0001);
        wait_presc(62);
        wr_d(4'b0000);
        chk("R3 release on wrap without pending", adv_cnt - a0, 1);

        // R3 collision: release in wrap cycle with one carry withheld
        wait_presc(30);
        a0 = adv_cnt;
        wr_d(4'b0001);
        wait_presc(10);
        wait_presc(62);
        wr_d(4'b0000);
        chk("R3 release on wrap with pending", adv_cnt - a0, 1);

        // R4 freeze taken inside the update window
        wait_presc(57);
        wr_d(4'b0001);
        chk("R4 sampled busy", int'(busy_o), 1);
        dig_wr_req_i = 1'b1;
        idle(1);
        chk("R5 write refused when busy sampled", int'(dig_wr_en_o), 0);
        dig_wr_req_i = 1'b0;
        a0 = adv_cnt;
        wait_presc(10);
        chk("R4 carry passes when busy sampled", adv_cnt - a0, 1);
        wr_d(4'b0000);

        // R6 / R7 / R8 rounding below 30
        wait_presc(5);
        sec_tens_i = 3'd2;
        c0 = clr_cnt; n0 = min_cnt;
        wr_d(4'b1000);
        chk("R6 clear pulse", clr_cnt - c0, 1);
        chk("R6 no minute carry below 30", min_cnt - n0, 0);
        wr_d(4'b1000);
        chk("R7 rewrite ignored", clr_cnt - c0, 1);
        wr_f(4'b0001);
        chk("R8 reset refused during rounding", int'(rest_o), 0);
        wr_d(4'b0001);
        dig_wr_req_i = 1'b1;
        idle(1);
        chk("R5 write refused during rounding", int'(dig_wr_en_o), 0);
        dig_wr_req_i = 1'b0;
        wr_d(4'b0000);
        idle(ADJ + 5);
        chk("R7 adjust self-clears", int'(adj_o), 0);

        // R6 rounding at 30 or more
        sec_tens_i = 3'd4;
        n0 = min_cnt;
        wr_d(4'b1000);
        chk("R6 minute carry at 40", min_cnt - n0, 1);
        idle(ADJ + 5);

        // R6 collision: rounding in wrap cycle
        wait_presc(62);
        a0 = adv_cnt;
        wr_d(4'b1000);
        chk("R6 advance suppressed by rounding", adv_cnt - a0, 0);
        idle(ADJ + 5);

        // R9 deselect clears freeze and reset, and blocks writes
        wr_d(4'b0001);
        wr_f(4'b0001);
        @(negedge clk) chip_sel_i = 1'b0;
        @(negedge clk) chip_sel_i = 1'b1;
        chk("R9 hold dropped", int'(hold_o), 0);
        chk("R9 rest dropped", int'(rest_o), 0);
        chip_sel_i = 1'b0;
        wr_d(4'b0001);
        chip_sel_i = 1'b1;
        chk("R9 write ignored when deselected", int'(hold_o), 0);
        idle(5);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule